// File: doc/BRIEF.md
# Q15 Sign-Magnitude Fractional Multiplier

This block multiplies two signed 16-bit Q15 fractions. Q15 values have no integer bits, so they cover the range from -1.0 up to just below +1.0 in steps of 2^-15. The block does not use a signed multiply. It works in sign-magnitude form instead. Each negative operand is turned into a positive magnitude, and the two magnitudes go to an unsigned multiplier. The raw product is then realigned to Q15 and its low bits are dropped. Finally the sign, taken as the XOR of the operand signs, is applied back by two's complement negation.

The operands are taken in on a clock edge together with an input valid flag. The registered product and its valid flag appear one clock later. When no valid operand pair arrives, the output register keeps its last value. The single product that cannot be represented in Q15, (-1.0) × (-1.0), saturates to the largest positive value.

Top module: `q15_mult_sm`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `prod` is 0x0000 until the first valid operand pair is captured.
- R2: `out_valid` is 1 in the cycle right after an edge where `in_valid` was 1, and 0 after an edge where `in_valid` was 0.
- R3: For operands of the same sign, `prod` equals the exact product a·b/2^15 truncated toward zero. For example, 0xA000 (-0.75) × 0xC000 (-0.5) gives 0x3000 (0.375).
- R4: When exactly one operand is negative, `prod` is the two's complement of the truncated magnitude. This means the result is a·b/2^15 truncated toward zero, and bit 15 of `prod` is 1 whenever that value is nonzero.
- R5: 0x8000 × 0x8000 gives 0x7FFF. No valid result is ever 0x8000.
- R6: A product whose truncated magnitude is zero gives 0x0000 even when the computed sign is negative. For example, 0xFFFF × 0x0001 gives 0x0000.
- R7: An operand of 0x8000 (-1.0) is used at its full magnitude. For example, 0x8000 × 0x4000 gives 0xC000, and 0x8000 × 0x7FFF gives 0x8001.
- R8: After an edge where `in_valid` is 0, `prod` keeps its previous value whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid, captured on the clock edge |
| op_a | input | 16 | First Q15 operand |
| op_b | input | 16 | Second Q15 operand |
| out_valid | output | 1 | Registered product valid |
| prod | output | 16 | Registered Q15 product |

## Verification
Two functions can fall in the same cycle. The -1.0 × -1.0 pair makes the XOR sign come out positive at the same moment as the overflow guard fires, so sign restoration and saturation must agree there. A negative computed sign can also meet a magnitude that truncates to zero, so negation and the zero result must agree. The bench provokes both cases with a full cross of corner operands: ±1 LSB, ±0.5, ±0.75, -1.0 and zero. It then sweeps a strided grid over the whole operand range. Every result is judged against a wide signed product, divided by 2^15 with truncation toward zero and then saturated.

// File: rtl/q15_mult_sm.sv
module q15_mult_sm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  mag_a, mag_b, mag_q, res;
  logic [PW-1:0] raw;
  logic          neg, ovf;

  assign mag_a = op_a[W-1] ? (~op_a + W'(1)) : op_a;
  assign mag_b = op_b[W-1] ? (~op_b + W'(1)) : op_b;
  assign neg   = op_a[W-1] ^ op_b[W-1];
  assign raw   = PW'(mag_a) * PW'(mag_b);
  assign mag_q = W'(raw >> (W - 1));
  assign ovf   = mag_q[W-1] & ~neg;
  assign res   = ovf ? MAX_POS : (neg ? (~mag_q + W'(1)) : mag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod <= res;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(prod)); // R8
  AST_LIKE_SIGNS_POS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op_a[W-1] == op_b[W-1])) |=> !prod[W-1]); // R3
  AST_SAT_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_a == MIN_NEG && op_b == MIN_NEG) |=> prod == MAX_POS); // R5
  AST_NEVER_MIN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> prod != MIN_NEG); // R5
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op_a == '0 || op_b == '0)) |=> prod == '0); // R6
endmodule

// File: tb/q15_mult_sm_tb.sv
module q15_mult_sm_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [15:0] prod;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  q15_mult_sm #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .prod(prod)
  );

  function automatic logic [15:0] ref_prod(logic [15:0] a, logic [15:0] b);
    int p, q;
    p = $signed(a) * $signed(b);
    q = p / 32768;
    if (q > 32767) q = 32767;
    return q[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_pair(logic [15:0] a, logic [15:0] b);
    logic [15:0] e;
    string tag;
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    e = ref_prod(a, b);
    if (a == 16'h8000 && b == 16'h8000) tag = "R5";
    else if (e == 16'h0000 && (a[15] ^ b[15])) tag = "R6";
    else if (a == 16'h8000 || b == 16'h8000) tag = "R7";
    else if (a[15] ^ b[15]) tag = "R4";
    else tag = "R3";
    check("R2 out_valid", {15'd0, out_valid}, 16'h0001);
    check(tag, prod, e);
  endtask

  initial begin
    logic [15:0] corners [12];
    logic [15:0] held;
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h4000, 16'hC000, 16'h6000,
                16'hA000, 16'h8000, 16'h7FFF, 16'h8001, 16'h2000, 16'hE000};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid", {15'd0, out_valid}, 16'h0000);
    check("R1 prod", prod, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {15'd0, out_valid}, 16'h0000);
    check("R1 prod after release", prod, 16'h0000);

    run_pair(16'hA000, 16'hC000);
    check("R3 example", prod, 16'h3000);
    run_pair(16'h8000, 16'h8000);
    check("R5 saturate", prod, 16'h7FFF);
    run_pair(16'hFFFF, 16'h0001);
    check("R6 negative zero", prod, 16'h0000);
    run_pair(16'h8000, 16'h4000);
    check("R7 full magnitude", prod, 16'hC000);
    run_pair(16'h8000, 16'h7FFF);
    check("R7 near min", prod, 16'h8001);

    foreach (corners[i])
      foreach (corners[j])
        run_pair(corners[i], corners[j]);

    // R8: idle cycles with changing operands leave prod alone
    run_pair(16'h6000, 16'h6000);
    held = prod;
    @(negedge clk);
    in_valid = 1'b0; op_a = 16'h8000; op_b = 16'h8000;
    @(negedge clk);
    check("R2 out_valid low", {15'd0, out_valid}, 16'h0000);
    check("R8 hold", prod, held);
    op_a = 16'h1234; op_b = 16'hFEDC;
    @(negedge clk);
    check("R8 hold again", prod, held);

    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 128; j++)
        run_pair(16'(-32768 + i * 516), 16'(-32768 + j * 516));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule